// File: doc/BRIEF.md
# At-Speed Self-Test Result Engine for Six Deserializer Lanes

This block runs the at-speed link self-test for a group of deserializer lanes. A test instruction is loaded first. The test-access controller must then enter its idle/run state within a bounded number of system clocks. When it does, every lane checks its received 10-bit words against a pseudo-random reference stream for a fixed number of words. The reference stream starts from the lane's own received data.

When the run ends, each lane reports two flags: a complete flag and a pass flag. A lane passes when its count of mismatched bits stays at or below a small threshold. That threshold stands in for a bit-error-rate limit of about one error in 10^7 bits over the default run of 2^21 words. If the idle/run entry comes too late, the run never starts. Every lane then reports complete with fail.

The 12-bit result is loaded into a shift register by a capture strobe and shifted out serially, least significant bit first. The full test-access controller is outside this block. It is represented by four strobes: instruction loaded, idle entered, capture and shift.

The sequencer has five states:
- IDLE is the state after reset.
- ARMED means the instruction is loaded and the start window is open.
- RUN means words are being checked.
- DONE means the run finished.
- LATE means the start window expired.

It has these transitions:
- From any state, a load goes to ARMED and the window restarts.
- ARMED goes to RUN when idle entry is seen inside the window.
- ARMED goes to LATE when the window expires.
- RUN goes to DONE after the last word.

Top module: `bist_result_top`

## Requirements
- R1: Result bit 2c+1 is the complete flag of lane c and bit 2c is its pass flag (1 = pass). Lane c takes its data from rx_words[10c+9:10c], and lane 0 owns bits 1:0.
- R2: The reference stream obeys b[n] = b[n-15] XOR b[n-14]. Bit k of a word is the k-th bit in time. The first two words of a run seed the checker, and the following RUN_WORDS words are checked, one word per clock.
- R3: Each mismatched bit counts once, including several in one word. A lane passes when its count is at most ERR_LIMIT (default 2).
- R4: The complete flags read 0 in IDLE, ARMED and RUN, so a capture during a run reads all zeros.
- R5: idle_enter is accepted only if it is sampled within START_WIN clock edges after the edge that sampled the load. Otherwise the engine goes to LATE and the result reads complete=1 and pass=0 for every lane.
- R6: A load in any state returns the engine to ARMED and restarts the start window. A load wins over idle_enter in the same cycle.
- R7: idle_enter with no instruction loaded has no effect.
- R8: Words received after a run finishes do not change the result, which holds until the next load.
- R9: cap_dr loads the result into the shift register. shift_dr moves it one place toward bit 0 with tdi entering bit 11, and tdo shows bit 0. Capture wins over shift.
- R10: After reset the engine is in IDLE, and the shift register and tdo are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_load | input | 1 | Pulse: test instruction loaded |
| idle_enter | input | 1 | Pulse: controller entered idle/run state |
| rx_words | input | NCH*WORD_W | Received words, lane c at bits 10c+9:10c |
| cap_dr | input | 1 | Capture result into shift register |
| shift_dr | input | 1 | Shift register one place toward bit 0 |
| tdi | input | 1 | Serial input into bit 11 |
| tdo | output | 1 | Serial output, bit 0 of shift register |

## Verification
The bench builds the engine with RUN_WORDS=40 and START_WIN=16, keeping NCH=6, WORD_W=10 and ERR_LIMIT=2. The short run allows several full runs in one simulation: clean runs, error counts on both sides of the threshold, and several errors inside one word. The small window makes both the last accepted idle entry and the first rejected one reachable, as well as the restart of the window by a second load.

// File: rtl/bist_pkg.sv
package bist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_RUN,
        ST_DONE,
        ST_LATE
    } bist_state_e;

    localparam int PRBS_LEN  = 15;
    localparam int SEED_WORDS = 2;

endpackage

// File: rtl/bist_seq.sv
module bist_seq
    import bist_pkg::*;
#(
    parameter int RUN_WORDS = 2097152,
    parameter int START_WIN = 4096,
    localparam int WCW = $clog2(RUN_WORDS + SEED_WORDS) + 1,
    localparam int WNW = $clog2(START_WIN) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        instr_load,
    input  logic        idle_enter,
    output bist_state_e st_o,
    output logic [WNW-1:0] win_cnt_o,
    output logic        clear_o,
    output logic        seed_o,
    output logic        check_o
);

    bist_state_e st_q, st_d;
    logic [WCW-1:0] wcnt_q;
    logic [WNW-1:0] win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (instr_load) begin
            st_d = ST_ARMED;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_IDLE;
                ST_ARMED: begin
                    if (idle_enter)                         st_d = ST_RUN;
                    else if (win_q == WNW'(START_WIN - 1))  st_d = ST_LATE;
                end
                ST_RUN:   if (wcnt_q == WCW'(RUN_WORDS + SEED_WORDS - 1)) st_d = ST_DONE;
                ST_DONE:  st_d = ST_DONE;
                ST_LATE:  st_d = ST_LATE;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= '0;
            wcnt_q <= '0;
        end else begin
            if (instr_load)           win_q <= '0;
            else if (st_q == ST_ARMED) win_q <= win_q + 1'b1;
            if (st_q == ST_RUN)       wcnt_q <= wcnt_q + 1'b1;
            else                      wcnt_q <= '0;
        end
    end

    always_comb begin
        st_o      = st_q;
        win_cnt_o = win_q;
        clear_o   = (st_q == ST_ARMED) && (st_d == ST_RUN);
        seed_o    = (st_q == ST_RUN) && (wcnt_q < WCW'(SEED_WORDS));
        check_o   = (st_q == ST_RUN) && (wcnt_q >= WCW'(SEED_WORDS));
    end

endmodule

// File: rtl/bist_lane_chk.sv
module bist_lane_chk
    import bist_pkg::*;
#(
    parameter int WORD_W    = 10,
    parameter int ERR_LIMIT = 2,
    localparam int CW = $clog2(ERR_LIMIT + WORD_W + 2) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              seed,
    input  logic              check,
    input  logic [WORD_W-1:0] word,
    output logic              pass_o
);

    logic [PRBS_LEN-1:0] hist_q;
    logic [CW-1:0]       err_q;
    logic [PRBS_LEN-1:0] gen_h, seed_h;
    logic [WORD_W-1:0]   exp_w;
    logic [CW-1:0]       sum;

    // Reference advance and seeding shift, one word of bits per clock
    always_comb begin
        logic [PRBS_LEN-1:0] h;
        logic [PRBS_LEN-1:0] s;
        logic b;
        h = hist_q;
        s = hist_q;
        exp_w = '0;
        for (int k = 0; k < WORD_W; k++) begin
            b        = h[PRBS_LEN-1] ^ h[PRBS_LEN-2];
            exp_w[k] = b;
            h        = {h[PRBS_LEN-2:0], b};
            s        = {s[PRBS_LEN-2:0], word[k]};
        end
        gen_h  = h;
        seed_h = s;
        sum    = err_q + CW'($countones(exp_w ^ word));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
            err_q  <= '0;
        end else if (clear) begin
            err_q <= '0;
        end else if (seed) begin
            hist_q <= seed_h;
        end else if (check) begin
            hist_q <= gen_h;
            err_q  <= (sum > CW'(ERR_LIMIT + 1)) ? CW'(ERR_LIMIT + 1) : sum;
        end
    end

    assign pass_o = (err_q <= CW'(ERR_LIMIT));

endmodule

// File: rtl/bist_result_reg.sv
module bist_result_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_dr,
    input  logic         shift_dr,
    input  logic         tdi,
    input  logic [W-1:0] result,
    output logic [W-1:0] sr_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sr_o <= '0;
        else if (cap_dr)   sr_o <= result;
        else if (shift_dr) sr_o <= {tdi, sr_o[W-1:1]};
    end

endmodule

// File: rtl/bist_result_top.sv
module bist_result_top
    import bist_pkg::*;
#(
    parameter int NCH       = 6,
    parameter int WORD_W    = 10,
    parameter int RUN_WORDS = 2097152,
    parameter int START_WIN = 4096,
    parameter int ERR_LIMIT = 2,
    localparam int RW  = 2 * NCH,
    localparam int WNW = $clog2(START_WIN) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  instr_load,
    input  logic                  idle_enter,
    input  logic [NCH*WORD_W-1:0] rx_words,
    input  logic                  cap_dr,
    input  logic                  shift_dr,
    input  logic                  tdi,
    output logic                  tdo
);

    bist_state_e    st;
    logic [WNW-1:0] win_cnt;
    logic           clear, seed, check;
    logic [NCH-1:0] lane_pass;
    logic [RW-1:0]  result_w;
    logic [RW-1:0]  shift_q;
    logic           armed_w, done_w, late_w;

    bist_seq #(.RUN_WORDS(RUN_WORDS), .START_WIN(START_WIN)) u_seq (
        .clk(clk), .rst_n(rst_n), .instr_load(instr_load), .idle_enter(idle_enter),
        .st_o(st), .win_cnt_o(win_cnt), .clear_o(clear), .seed_o(seed), .check_o(check)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        bist_lane_chk #(.WORD_W(WORD_W), .ERR_LIMIT(ERR_LIMIT)) u_lane (
            .clk(clk), .rst_n(rst_n), .clear(clear), .seed(seed), .check(check),
            .word(rx_words[c*WORD_W +: WORD_W]), .pass_o(lane_pass[c])
        );
        assign result_w[2*c+1] = done_w | late_w;
        assign result_w[2*c]   = done_w & lane_pass[c];
    end

    always_comb begin
        armed_w = (st == ST_ARMED);
        done_w  = (st == ST_DONE);
        late_w  = (st == ST_LATE);
    end

    bist_result_reg #(.W(RW)) u_reg (
        .clk(clk), .rst_n(rst_n), .cap_dr(cap_dr), .shift_dr(shift_dr),
        .tdi(tdi), .result(result_w), .sr_o(shift_q)
    );

    assign tdo = shift_q[0];

endmodule

// File: rtl/bist_result_chk.sv
module bist_result_chk #(
    parameter int NCH       = 6,
    parameter int START_WIN = 4096,
    localparam int RW  = 2 * NCH,
    localparam int WNW = $clog2(START_WIN) + 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cap_dr,
    input logic           shift_dr,
    input logic           tdi,
    input logic [RW-1:0]  result,
    input logic [RW-1:0]  sr_q,
    input logic           armed,
    input logic           done,
    input logic [WNW-1:0] win_cnt
);

    logic [NCH-1:0] comp;
    always_comb for (int c = 0; c < NCH; c++) comp[c] = result[2*c+1];

    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_dr |=> sr_q == $past(result));

    p_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_dr && !cap_dr) |=> sr_q == {$past(tdi), $past(sr_q[RW-1:1])});

    p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> win_cnt < WNW'(START_WIN));

    p_complete_uniform_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (comp == '0) || (comp == '1));

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> $stable(result));

    for (genvar c = 0; c < NCH; c++) begin : g_pc
        p_pass_needs_complete_r4: assert property (@(posedge clk) disable iff (!rst_n)
            result[2*c] |-> result[2*c+1]);
    end

endmodule

bind bist_result_top bist_result_chk #(.NCH(NCH), .START_WIN(START_WIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .cap_dr(cap_dr), .shift_dr(shift_dr), .tdi(tdi),
    .result(result_w), .sr_q(shift_q), .armed(armed_w), .done(done_w), .win_cnt(win_cnt)
);

// File: tb/tb_bist_result_top.sv
module tb_bist_result_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 6;
    localparam int WW = 10;
    localparam int RUNW = 40;
    localparam int WIN = 16;
    localparam int TOTAL = RUNW + 2;
    localparam logic [11:0] TDI_PAT = 12'h5C3;

    logic clk = 0, rst_n = 0;
    logic instr_load = 0, idle_enter = 0, cap_dr = 0, shift_dr = 0, tdi = 0;
    logic [NCH*WW-1:0] rx_words = '0;
    logic tdo;

    int n_tests = 0, n_fail = 0;

    typedef struct { logic [11:0] val; string tag; } exp_t;
    exp_t exp_q[$];
    logic [11:0] obs;
    event obs_ev;

    bist_result_top #(.NCH(NCH), .WORD_W(WW), .RUN_WORDS(RUNW), .START_WIN(WIN), .ERR_LIMIT(2)) dut (
        .clk(clk), .rst_n(rst_n), .instr_load(instr_load), .idle_enter(idle_enter),
        .rx_words(rx_words), .cap_dr(cap_dr), .shift_dr(shift_dr), .tdi(tdi), .tdo(tdo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: pops the expected result and compares it with the observed one
    initial forever begin
        exp_t e;
        @(obs_ev);
        e = exp_q.pop_front();
        n_tests++;
        if (obs !== e.val) begin
            n_fail++;
            $display("FAIL %s: got %03h expected %03h", e.tag, obs, e.val);
        end
    end

    function automatic void gen_word(inout logic [14:0] h, output logic [WW-1:0] w);
        for (int k = 0; k < WW; k++) begin
            w[k] = h[14] ^ h[13];
            h = {h[13:0], w[k]};
        end
    endfunction

    function automatic logic [11:0] exp_run(input int errs[NCH]);
        logic [11:0] r;
        for (int c = 0; c < NCH; c++) begin
            r[2*c+1] = 1'b1;
            r[2*c]   = (errs[c] <= 2);
        end
        return r;
    endfunction

    task automatic load_pulse();
        @(negedge clk) instr_load = 1;
        @(negedge clk) instr_load = 0;
    endtask

    task automatic start(input int d);
        load_pulse();
        repeat (d) @(negedge clk);
        idle_enter = 1;
    endtask

    task automatic feed(input int nwords, input int errs[NCH], input bit same);
        logic [14:0] h[NCH];
        logic [WW-1:0] w;
        for (int c = 0; c < NCH; c++) h[c] = 15'((c * 4663 + 77) | 1);
        for (int j = 0; j < nwords; j++) begin
            @(negedge clk);
            idle_enter = 0;
            for (int c = 0; c < NCH; c++) begin
                gen_word(h[c], w);
                for (int i = 0; i < errs[c]; i++)
                    if (j == (same ? 5 : 2 + 3 * i)) w[i] = ~w[i];
                rx_words[c*WW +: WW] = w;
            end
        end
        @(negedge clk);
    endtask

    task automatic read(input bit capture, input logic [11:0] e, input string tag);
        exp_q.push_back('{e, tag});
        if (capture) begin
            @(negedge clk) cap_dr = 1;
            @(negedge clk) cap_dr = 0;
        end
        for (int b = 0; b < 12; b++) begin
            obs[b] = tdo;
            shift_dr = 1;
            tdi = TDI_PAT[b];
            @(negedge clk);
        end
        shift_dr = 0;
        ->obs_ev;
        #1;
    endtask

    initial begin
        int none[NCH] = '{0, 0, 0, 0, 0, 0};
        int e1[NCH]   = '{2, 3, 0, 0, 0, 1};
        int e2[NCH]   = '{0, 0, 3, 0, 0, 0};
        int e3[NCH]   = '{0, 0, 0, 0, 0, 3};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        n_tests++;
        if (tdo !== 1'b0) begin n_fail++; $display("FAIL R10: tdo got %b expected 0", tdo); end
        read(1, 12'h000, "R10 reset result");
        // idle entry without an instruction
        @(negedge clk) idle_enter = 1;
        feed(TOTAL, none, 0);
        read(1, 12'h000, "R7 idle entry ignored");
        start(3); feed(TOTAL, none, 0);
        read(1, 12'hFFF, "R2 clean run all pass");
        // garbage after done
        repeat (10) @(negedge clk) rx_words = ~rx_words;
        read(1, 12'hFFF, "R8 words after done ignored");
        start(1); feed(TOTAL, e1, 0);
        read(1, exp_run(e1), "R3 threshold 2 pass 3 fail");
        start(2); feed(TOTAL, e2, 1);
        read(1, exp_run(e2), "R3 three errors in one word");
        start(5); feed(TOTAL, e3, 0);
        read(1, 12'hBFF, "R1 lane 5 at bits 11:10");
        start(WIN - 1); feed(TOTAL, none, 0);
        read(1, 12'hFFF, "R5 last accepted cycle");
        load_pulse();
        repeat (WIN + 4) @(negedge clk);
        read(1, 12'hAAA, "R5 late start complete fail");
        load_pulse();
        repeat (10) @(negedge clk);
        start(10); feed(TOTAL, none, 0);
        read(1, 12'hFFF, "R6 reload restarts window");
        start(0); feed(10, none, 0);
        read(1, 12'h000, "R4 capture mid run");
        read(0, TDI_PAT, "R9 shifted-in pattern");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * CLK_PERIOD);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule